// File: doc/BRIEF.md
# Asynchronous NAND Bus Access Sequencer

This block turns single-byte requests from an internal master into timed cycles on an asynchronous 8-bit external memory bus that a NAND flash device sits on. A request carries a direction, a byte address and, for writes, one data byte. The block answers each request with a one-cycle completion pulse and, for reads, the captured byte. On the bus it drives an active-low chip select, an active-low read strobe and an active-low write strobe. It also drives the two NAND latch enables, for command and for address, which it decodes from fixed byte-address bits. A second die is reached by ORing a programmable mask into the address.

Each access runs through three phases: setup, strobe and hold. The lengths of these phases are programmed separately for reads and writes in one packed 32-bit timing word. A turnaround gap follows every access before the next request can be taken. The timing word and the request fields are captured when a request is accepted, so a change to them during an access has no effect on it. The shared ready/busy line of the NAND devices enters through a synchronizer and is presented as a status bit.

Top module: `nand_port_seq`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, both latch enables and `done` are low, `req_ready` is high and `dev_ready` is low.
- R2: A write uses timing-word fields write setup [29:26], write strobe [25:20] and write hold [19:17]. Each phase lasts its field value plus one cycle, and the write strobe is low only during the strobe phase.
- R3: A read uses read setup [16:13], read strobe [12:7] and read hold [6:4], each lasting its value plus one cycle, with the read strobe low only during the strobe phase. The bus data present on the last strobe cycle appears on `rd_data` by the `done` cycle.
- R4: `done` is high for exactly one cycle, the last hold cycle of each access.
- R5: After the `done` cycle, `req_ready` stays low for turnaround field [3:2] plus one cycles.
- R6: When bit 31 of the timing word is 0, chip select is low across setup, strobe and hold. When it is 1, chip select is low only during the strobe phase.
- R7: The address latch enable follows byte-address bit 3 and the command latch enable follows bit 4 during an access. When both bits are set, only the command latch enable is asserted.
- R8: Address bits [1:0] are always driven as zero on the bus.
- R9: When `die_sel` is high at acceptance, the bus address is the request address ORed with `die_mask`. Otherwise it is the request address unchanged.
- R10: `dev_ready` follows `mem_rdy` after two rising clock edges.
- R11: Timing-word bit 30 and the bus-size field [1:0] have no effect on phase lengths. The timing word is sampled only when a request is accepted.
- R12: During a write access the bus data output carries the write byte with its output enable high. During a read access the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Packed phase timing word |
| die_mask | input | ADDR_W | Address mask ORed in for the second die |
| die_sel | input | 1 | Selects the second die for the request |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Sequencer idle and able to accept |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte |
| dev_ready | output | 1 | Synchronized device ready status |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ale | output | 1 | Address latch enable |
| mem_cle | output | 1 | Command latch enable |
| mem_addr | output | ADDR_W | Bus address |
| mem_dq_out | output | 8 | Bus data out |
| mem_dq_oe | output | 1 | Bus data output enable |
| mem_dq_in | input | 8 | Bus data in |
| mem_rdy | input | 1 | Wired-AND ready/busy line |

## Verification
The hardest case to reach from the ports is a timing word that changes while an access is under way. The strobe and hold lengths must still follow the word captured at acceptance. The bench accepts a request and rewrites `cfg_word` on the very next cycle with very different field values. It then measures each phase length cycle by cycle against the original word. A second difficult point is that bits that must be ignored (bit 30, the bus-size field) can only be seen through phase lengths. The bench therefore repeats an access with those bits set and compares its phase counts with those of the plain word.

// File: rtl/nps_pkg.sv
package nps_pkg;

  localparam int CNT_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_TURN
  } phase_e;

  typedef struct packed {
    logic             sel_strobe;
    logic [3:0]       wr_setup;
    logic [5:0]       wr_strobe;
    logic [2:0]       wr_hold;
    logic [3:0]       rd_setup;
    logic [5:0]       rd_strobe;
    logic [2:0]       rd_hold;
    logic [1:0]       turn;
  } timing_t;

  // Pull the phase fields out of the packed word; bit 30 and [1:0] unused.
  function automatic timing_t unpack_timing(input logic [31:0] w);
    timing_t t;
    t.sel_strobe = w[31];
    t.wr_setup   = w[29:26];
    t.wr_strobe  = w[25:20];
    t.wr_hold    = w[19:17];
    t.rd_setup   = w[16:13];
    t.rd_strobe  = w[12:7];
    t.rd_hold    = w[6:4];
    t.turn       = w[3:2];
    return t;
  endfunction

  // Counter preload on entry to a phase: the phase lasts preload + 1 cycles.
  function automatic logic [CNT_W-1:0] phase_preload(input phase_e ph,
                                                     input logic wr,
                                                     input timing_t t);
    logic [CNT_W-1:0] v;
    v = '0;
    case (ph)
      PH_SETUP:  v = wr ? CNT_W'(t.wr_setup)  : CNT_W'(t.rd_setup);
      PH_STROBE: v = wr ? CNT_W'(t.wr_strobe) : CNT_W'(t.rd_strobe);
      PH_HOLD:   v = wr ? CNT_W'(t.wr_hold)   : CNT_W'(t.rd_hold);
      PH_TURN:   v = CNT_W'(t.turn);
      default:   v = '0;
    endcase
    return v;
  endfunction

  // Latch-enable decode: command enable wins when both bits are set.
  function automatic logic [1:0] latch_decode(input logic ale_bit,
                                              input logic cle_bit);
    return {cle_bit, ale_bit & ~cle_bit};
  endfunction

endpackage

// File: rtl/nps_sync.sv
module nps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic mid
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q   = chain[STAGES-1];
  assign mid = chain[STAGES-2];
endmodule

// File: rtl/nps_addr_map.sv
module nps_addr_map #(
  parameter int ADDR_W  = 16,
  parameter int ALE_BIT = 3,
  parameter int CLE_BIT = 4
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              die_q,
  input  logic [ADDR_W-1:0] mask_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              ale,
  output logic              cle
);
  import nps_pkg::*;
  localparam logic [ADDR_W-1:0] LOW_CLR = ~ADDR_W'(3);

  logic [ADDR_W-1:0] merged;
  logic [1:0]        le;

  assign merged   = addr_in | (die_q ? mask_q : '0);
  assign bus_addr = merged & LOW_CLR;
  assign le       = latch_decode(merged[ALE_BIT], merged[CLE_BIT]);
  assign cle      = le[1];
  assign ale      = le[0];
endmodule

// File: rtl/nps_fsm.sv
module nps_fsm #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              die_sel,
  input  logic [ADDR_W-1:0] die_mask,
  input  logic [DATA_W-1:0] dq_in,
  output nps_pkg::phase_e   phase,
  output logic              last_cyc,
  output logic              op_wr,
  output logic              sel_strobe,
  output logic [ADDR_W-1:0] addr_q,
  output logic              die_q,
  output logic [ADDR_W-1:0] mask_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  import nps_pkg::*;

  timing_t          tim_q;
  logic [CNT_W-1:0] cnt;
  timing_t          tim_new;

  assign tim_new    = unpack_timing(cfg_word);
  assign last_cyc   = (cnt == '0);
  assign sel_strobe = tim_q.sel_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      tim_q   <= '0;
      op_wr   <= 1'b0;
      addr_q  <= '0;
      die_q   <= 1'b0;
      mask_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (req_valid) begin
          tim_q   <= tim_new;
          op_wr   <= req_write;
          addr_q  <= req_addr;
          die_q   <= die_sel;
          mask_q  <= die_mask;
          wdata_q <= req_wdata;
          cnt     <= phase_preload(PH_SETUP, req_write, tim_new);
          phase   <= PH_SETUP;
        end
        PH_SETUP: if (last_cyc) begin
          cnt   <= phase_preload(PH_STROBE, op_wr, tim_q);
          phase <= PH_STROBE;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (last_cyc) begin
          if (!op_wr) rdata_q <= dq_in;
          cnt   <= phase_preload(PH_HOLD, op_wr, tim_q);
          phase <= PH_HOLD;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (last_cyc) begin
          cnt   <= phase_preload(PH_TURN, op_wr, tim_q);
          phase <= PH_TURN;
        end else cnt <= cnt - 1'b1;
        PH_TURN: if (last_cyc) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_port_seq.sv
module nand_port_seq #(
  parameter int ADDR_W      = 16,
  parameter int ALE_BIT     = 3,
  parameter int CLE_BIT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic [ADDR_W-1:0] die_mask,
  input  logic              die_sel,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic              dev_ready,
  output logic              mem_cs_n,
  output logic              mem_re_n,
  output logic              mem_we_n,
  output logic              mem_ale,
  output logic              mem_cle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [7:0]        mem_dq_in,
  input  logic              mem_rdy
);
  import nps_pkg::*;

  phase_e            phase;
  logic              last_cyc, op_wr, sel_strobe, die_q;
  logic [ADDR_W-1:0] addr_q, mask_q, bus_addr;
  logic [7:0]        wdata_q;
  logic              dec_ale, dec_cle, rdy_mid;
  logic              in_access, in_strobe;

  nps_fsm #(.ADDR_W(ADDR_W), .DATA_W(8)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .die_sel(die_sel), .die_mask(die_mask),
    .dq_in(mem_dq_in), .phase(phase), .last_cyc(last_cyc), .op_wr(op_wr),
    .sel_strobe(sel_strobe), .addr_q(addr_q), .die_q(die_q),
    .mask_q(mask_q), .wdata_q(wdata_q), .rdata_q(rd_data)
  );

  nps_addr_map #(.ADDR_W(ADDR_W), .ALE_BIT(ALE_BIT), .CLE_BIT(CLE_BIT)) u_map (
    .addr_in(addr_q), .die_q(die_q), .mask_q(mask_q),
    .bus_addr(bus_addr), .ale(dec_ale), .cle(dec_cle)
  );

  nps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mem_rdy), .q(dev_ready), .mid(rdy_mid)
  );

  assign in_access  = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_strobe  = (phase == PH_STROBE);
  assign req_ready  = (phase == PH_IDLE);
  assign done       = (phase == PH_HOLD) && last_cyc;
  assign mem_cs_n   = ~(sel_strobe ? in_strobe : in_access);
  assign mem_re_n   = ~(in_strobe && !op_wr);
  assign mem_we_n   = ~(in_strobe && op_wr);
  assign mem_ale    = in_access && dec_ale;
  assign mem_cle    = in_access && dec_cle;
  assign mem_addr   = in_access ? bus_addr : '0;
  assign mem_dq_oe  = in_access && op_wr;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/nps_checker.sv
module nps_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              done,
  input logic              dev_ready,
  input logic              rdy_mid,
  input logic              mem_cs_n,
  input logic              mem_re_n,
  input logic              mem_we_n,
  input logic              mem_ale,
  input logic              mem_cle,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_re_n && mem_we_n));
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_re_n && !mem_we_n));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_turn_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !req_ready);
  p_strobe_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_re_n || !mem_we_n) |-> !mem_cs_n);
  p_latch_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_ale && mem_cle));
  p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[1:0] == 2'b00);
  p_sync_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready == $past(rdy_mid));
  p_oe_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !req_ready);
endmodule

bind nand_port_seq nps_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .dev_ready(dev_ready), .rdy_mid(rdy_mid), .mem_cs_n(mem_cs_n),
  .mem_re_n(mem_re_n), .mem_we_n(mem_we_n), .mem_ale(mem_ale),
  .mem_cle(mem_cle), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/nand_port_seq_bench.sv
module nand_port_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic [15:0] die_mask = '0;
  logic        die_sel = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done, dev_ready;
  logic [7:0]  rd_data, mem_dq_out;
  logic        mem_cs_n, mem_re_n, mem_we_n, mem_ale, mem_cle, mem_dq_oe;
  logic [15:0] mem_addr;
  logic [7:0]  mem_dq_in = '0;
  logic        mem_rdy = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nand_port_seq u_nand_port_seq (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .die_mask(die_mask),
    .die_sel(die_sel), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .dev_ready(dev_ready),
    .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
    .mem_ale(mem_ale), .mem_cle(mem_cle), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_rdy(mem_rdy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit ss, input bit ew,
      input int ws, input int wst, input int wh,
      input int rs, input int rst, input int rh, input int ta, input int bsz);
    logic [31:0] w;
    w = (32'(ss) << 31) | (32'(ew) << 30) | (32'(ws) << 26) | (32'(wst) << 20)
      | (32'(wh) << 17) | (32'(rs) << 13) | (32'(rst) << 7) | (32'(rh) << 4)
      | (32'(ta) << 2) | 32'(bsz);
    return w;
  endfunction

  // Results of one measured access
  int   n_set, n_str, n_hold, n_cs, n_turn;
  bit   s_ale, s_cle, s_oe, done_after;
  logic [15:0] s_addr;
  logic [7:0]  s_dq, s_rd;

  task automatic run_access(input bit wr, input logic [15:0] a, input logic [7:0] wd,
                            input bit die, input logic [31:0] cfg_after);
    int guard;
    n_set = 0; n_str = 0; n_hold = 0; n_cs = 0; n_turn = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; die_sel = die;
    @(negedge clk);
    req_valid = 0; req_addr = 16'hFFFF; die_sel = 0; cfg_word = cfg_after;
    guard = 0;
    forever begin
      if (!mem_re_n || !mem_we_n) begin
        if (n_str == 0) begin
          s_ale = mem_ale; s_cle = mem_cle; s_addr = mem_addr;
          s_dq = mem_dq_out; s_oe = mem_dq_oe;
        end
        n_str++;
      end else if (n_str == 0) n_set++;
      else n_hold++;
      if (!mem_cs_n) n_cs++;
      if (done) begin s_rd = rd_data; break; end
      guard++;
      if (guard > 500) break;
      @(negedge clk);
    end
    @(negedge clk);
    done_after = done;
    while (!req_ready && n_turn < 500) begin
      n_turn++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    check(mem_cs_n && mem_re_n && mem_we_n, "R1 strobes idle high", {mem_cs_n, mem_re_n, mem_we_n}, 7);
    check(!mem_ale && !mem_cle && !done, "R1 latch/done low", {mem_ale, mem_cle, done}, 0);
    check(req_ready && !dev_ready, "R1 ready/status", {req_ready, dev_ready}, 2);
  endtask

  task automatic t_write;
    logic [31:0] c;
    c = mk_cfg(0, 0, 1, 3, 1, 0, 3, 0, 3, 0);
    cfg_word = c;
    run_access(1, 16'h0100, 8'h3C, 0, c);
    check(n_set == 2, "R2 write setup", n_set, 2);
    check(n_str == 4, "R2 write strobe", n_str, 4);
    check(n_hold == 2, "R2 write hold", n_hold, 2);
    check(n_cs == 8, "R6 cs whole access", n_cs, 8);
    check(s_oe && s_dq == 8'h3C, "R12 write data", s_dq, 8'h3C);
    check(!done_after, "R4 done single", done_after, 0);
    check(n_turn == 4, "R5 turnaround 3", n_turn, 4);
  endtask

  task automatic t_read;
    logic [31:0] c;
    c = mk_cfg(0, 0, 0, 1, 0, 2, 5, 2, 0, 0);
    cfg_word = c;
    mem_dq_in = 8'hA5;
    run_access(0, 16'h0200, 8'h00, 0, c);
    check(n_set == 3, "R3 read setup", n_set, 3);
    check(n_str == 6, "R3 read strobe", n_str, 6);
    check(n_hold == 3, "R3 read hold", n_hold, 3);
    check(s_rd == 8'hA5, "R3 read data", s_rd, 8'hA5);
    check(!s_oe, "R12 no drive on read", s_oe, 0);
    check(n_turn == 1, "R5 turnaround 0", n_turn, 1);
  endtask

  task automatic t_strobe_sel;
    logic [31:0] c;
    c = mk_cfg(1, 0, 2, 2, 2, 0, 0, 0, 0, 0);
    cfg_word = c;
    run_access(1, 16'h0000, 8'h11, 0, c);
    check(n_cs == 3 && n_str == 3, "R6 cs only on strobe", n_cs, 3);
  endtask

  task automatic t_latch;
    logic [31:0] c;
    c = mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cfg_word = c;
    run_access(1, 16'h0008, 8'h00, 0, c);
    check(s_ale && !s_cle, "R7 ale from bit3", {s_ale, s_cle}, 2);
    run_access(1, 16'h0010, 8'h70, 0, c);
    check(!s_ale && s_cle, "R7 cle from bit4", {s_ale, s_cle}, 1);
    run_access(0, 16'h0018, 8'h00, 0, c);
    check(!s_ale && s_cle, "R7 cle wins", {s_ale, s_cle}, 1);
    run_access(0, 16'h0123, 8'h00, 0, c);
    check(s_addr == 16'h0120, "R8 low bits dropped", s_addr, 16'h0120);
    check(!s_ale && !s_cle, "R7 neither", {s_ale, s_cle}, 0);
  endtask

  task automatic t_die;
    logic [31:0] c;
    c = mk_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cfg_word = c;
    die_mask = 16'h4000;
    run_access(0, 16'h0100, 8'h00, 1, c);
    check(s_addr == 16'h4100, "R9 second die", s_addr, 16'h4100);
    run_access(0, 16'h0100, 8'h00, 0, c);
    check(s_addr == 16'h0100, "R9 first die", s_addr, 16'h0100);
  endtask

  task automatic t_sync;
    @(negedge clk); mem_rdy = 1;
    @(negedge clk);
    check(!dev_ready, "R10 one edge", dev_ready, 0);
    @(negedge clk);
    check(dev_ready, "R10 two edges", dev_ready, 1);
    mem_rdy = 0;
    @(negedge clk); @(negedge clk);
    check(!dev_ready, "R10 falls", dev_ready, 0);
  endtask

  task automatic t_ignored;
    logic [31:0] c, cx;
    int ref_set, ref_str, ref_hold, ref_turn;
    c  = mk_cfg(0, 0, 3, 2, 4, 1, 1, 1, 2, 0);
    cx = mk_cfg(0, 1, 3, 2, 4, 1, 1, 1, 2, 3);
    cfg_word = c;
    run_access(1, 16'h0040, 8'h55, 0, c);
    ref_set = n_set; ref_str = n_str; ref_hold = n_hold; ref_turn = n_turn;
    check(ref_set == 4 && ref_str == 3 && ref_hold == 5, "R2 write lengths 2", ref_str, 3);
    cfg_word = cx;
    run_access(1, 16'h0040, 8'h55, 0, cx);
    check(n_set == ref_set && n_str == ref_str && n_hold == ref_hold && n_turn == ref_turn,
          "R11 bit30/size ignored", n_hold, ref_hold);
    cfg_word = c;
    run_access(1, 16'h0040, 8'h55, 0, mk_cfg(0, 0, 15, 63, 7, 15, 63, 7, 3, 0));
    check(n_str == 3 && n_hold == 5 && n_turn == 3, "R11 sampled at accept", n_str, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write;
    t_read;
    t_strobe_sel;
    t_latch;
    t_die;
    t_sync;
    t_ignored;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule